// File: doc/BRIEF.md
# Banked Video Memory Mapper

This block places a set of physical video RAM banks into three logical address windows: a direct window that shows every bank at a fixed slot, a background window and an object window. Each bank has its own control byte. The byte says whether the bank is switched on, which window it appears in, and at which base slot. Addresses are split into pages. A page is a parameterised run of words that stands for a 16 KB page of the full-size memory. Banks are 1, 4 or 8 pages in size.

Each window has its own read/write port. Reads are combinational. A read returns the bitwise OR of every bank that covers the address, and zero when no bank covers it. A write lands in every bank that covers the address. Small banks repeat inside their slot. The background and object windows repeat, or mirror, across the upper address bits. The bank RAMs are inferred arrays inside the block. Their contents survive any change of mapping.

Top module: `vmap`

## Requirements
- R1: A bank whose control bit 7 is 0 covers no address in any window.
- R2: Control bits [1:0] pick the target: 0 the direct window, 1 the background window, 2 the object window, 3 no window.
- R3: In the direct window, bank b covers pages 8*b up to 8*b+size-1. The rest of that 8-page slot reads zero.
- R4: An address that no bank covers reads as all zeros.
- R5: In the background window, control bits [4:3] give the base slot (base page 8*value). In the object window only bit 3 counts (base page 8*bit3).
- R6: A bank smaller than its 8-page slot repeats every size pages across the slot. A 4-page bank therefore appears twice.
- R7: A 1-page bank in the background or object window covers 8 consecutive pages. They start at page bit3 + 4*bit4 of its control byte.
- R8: The background window repeats every 32 pages and the object window every 16 pages. Higher page bits are ignored.
- R9: Where banks overlap, a read returns the OR of all covering banks, and a write updates every covering bank.
- R10: A control write is seen from the clock edge that takes it. Rewriting the same value, or remapping a bank, leaves its stored data unchanged.
- R11: Reset clears every control byte, so every window reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | NBANK | Per-bank control-byte write strobe |
| ctl_wdata | input | 8*NBANK | Control bytes, bank b in bits [8b+7:8b] |
| lcd_addr | input | LCD_AW | Direct window word address |
| lcd_we | input | 1 | Direct window write strobe |
| lcd_wdata | input | DW | Direct window write data |
| lcd_rdata | output | DW | Direct window read data |
| bg_addr | input | BG_AW | Background window word address |
| bg_we | input | 1 | Background window write strobe |
| bg_wdata | input | DW | Background window write data |
| bg_rdata | output | DW | Background window read data |
| obj_addr | input | OBJ_AW | Object window word address |
| obj_we | input | 1 | Object window write strobe |
| obj_wdata | input | DW | Object window write data |
| obj_rdata | output | DW | Object window read data |

## Verification
The hardest case to reach is a read over an overlap, where a single-page bank lies across parts of two full banks. The bits seen there are the OR of data that was last written through different logical addresses. The bench sets up such layouts in both mapped windows. It fills every page of the base span in address order, so the small bank is overwritten many times. It then reads every address, including the mirror copies, and compares each word against a page-table model of its own. Directed steps then move one bank between windows, to show that stored data survives remapping, and write through an overlap to show that the write reaches both banks.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int WIN_LCD = 0;
  localparam int WIN_BG  = 1;
  localparam int WIN_OBJ = 2;
  localparam int EN_BIT  = 7;
  localparam int SLOT_PAGES = 8;

  // first logical page that a bank occupies inside a window's base span
  function automatic int window_base(int win, int bank, int szlog, logic [7:0] c);
    if (win == WIN_LCD)   return bank * SLOT_PAGES;
    else if (szlog == 0)  return int'(c[3]) + 4 * int'(c[4]);
    else if (win == WIN_OBJ) return SLOT_PAGES * int'(c[3]);
    else                  return SLOT_PAGES * int'(c[4:3]);
  endfunction

  // number of pages covered from the base page on
  function automatic int window_span(int win, int szlog);
    if (win == WIN_LCD) return 1 << szlog;
    else                return SLOT_PAGES;
  endfunction
endpackage

// File: rtl/vmap_decode.sv
module vmap_decode #(
  parameter int WIN   = 0,
  parameter int BANK  = 0,
  parameter int SZLOG = 3
) (
  input  logic [7:0] ctl,
  input  logic [7:0] page,
  output logic       hit,
  output logic [2:0] lpage
);
  logic [8:0] base, span, rel, pg;
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl[6:5], ctl[2]};

  always_comb begin
    base  = 9'(vmap_pkg::window_base(WIN, BANK, SZLOG, ctl));
    span  = 9'(vmap_pkg::window_span(WIN, SZLOG));
    pg    = {1'b0, page};
    rel   = pg - base;
    hit   = ctl[vmap_pkg::EN_BIT] && (ctl[1:0] == 2'(WIN)) && (pg >= base) && (rel < span);
    lpage = rel[2:0] & 3'((1 << SZLOG) - 1);
  end
endmodule

// File: rtl/vmap_bank.sv
module vmap_bank #(
  parameter int BANK    = 0,
  parameter int SZLOG   = 3,
  parameter int PAGE_AW = 4,
  parameter int DW      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_we,
  input  logic [7:0]                ctl_wdata,
  input  logic [2:0][7:0]           win_page,
  input  logic [2:0][PAGE_AW-1:0]   win_off,
  input  logic [2:0]                win_we,
  input  logic [2:0][DW-1:0]        win_wdata,
  output logic [2:0][DW-1:0]        win_rdata,
  output logic [2:0]                win_hit
);
  localparam int LAW   = SZLOG + PAGE_AW;
  localparam int WORDS = 1 << LAW;

  logic [7:0]     ctl;
  logic [DW-1:0]  mem [WORDS];
  logic [2:0][2:0]     lpage;
  logic [2:0][LAW-1:0] laddr;
  logic           wr_en;
  logic [LAW-1:0] wr_addr;
  logic [DW-1:0]  wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (ctl_we) ctl <= ctl_wdata;

  for (genvar w = 0; w < 3; w++) begin : g_win
    vmap_decode #(.WIN(w), .BANK(BANK), .SZLOG(SZLOG)) u_dec (
      .ctl(ctl), .page(win_page[w]), .hit(win_hit[w]), .lpage(lpage[w]));
    assign laddr[w]     = LAW'({lpage[w], win_off[w]});
    assign win_rdata[w] = win_hit[w] ? mem[laddr[w]] : '0;
  end

  // a bank sits in at most one window, so at most one port can hit it
  always_comb begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int w = 0; w < 3; w++)
      if (win_hit[w] && win_we[w]) begin
        wr_en = 1'b1; wr_addr = laddr[w]; wr_data = win_wdata[w];
      end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  p_disabled_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[vmap_pkg::EN_BIT] |-> (win_hit == 3'b000));
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));
  p_mode3_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1:0] == 2'd3) |-> (win_hit == 3'b000));
  p_ctl_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl == $past(ctl_wdata)));
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/vmap.sv
module vmap #(
  parameter int NBANK      = 4,
  parameter int PAGE_AW    = 4,
  parameter int DW         = 16,
  parameter logic [2*NBANK-1:0] BANK_SZLOG = 8'b00_10_11_11,
  parameter int BG_MIR     = 1,
  parameter int OBJ_MIR    = 1,
  localparam int LCD_PGW   = $clog2(NBANK) + 3,
  localparam int LCD_AW    = LCD_PGW + PAGE_AW,
  localparam int BG_AW     = 5 + BG_MIR + PAGE_AW,
  localparam int OBJ_AW    = 4 + OBJ_MIR + PAGE_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NBANK-1:0]     ctl_we,
  input  logic [8*NBANK-1:0]   ctl_wdata,
  input  logic [LCD_AW-1:0]    lcd_addr,
  input  logic                 lcd_we,
  input  logic [DW-1:0]        lcd_wdata,
  output logic [DW-1:0]        lcd_rdata,
  input  logic [BG_AW-1:0]     bg_addr,
  input  logic                 bg_we,
  input  logic [DW-1:0]        bg_wdata,
  output logic [DW-1:0]        bg_rdata,
  input  logic [OBJ_AW-1:0]    obj_addr,
  input  logic                 obj_we,
  input  logic [DW-1:0]        obj_wdata,
  output logic [DW-1:0]        obj_rdata
);
  logic [2:0][7:0]         page;
  logic [2:0][PAGE_AW-1:0] off;
  logic [2:0]              we;
  logic [2:0][DW-1:0]      wdata;
  logic [NBANK-1:0][2:0][DW-1:0] brd;
  logic [NBANK-1:0][2:0]         bhit;
  logic [2:0][NBANK-1:0]         hits;
  logic unused_mirror_bits;

  // mirroring: only the low page bits of each window reach the decoders
  assign page[0] = 8'(lcd_addr[LCD_AW-1:PAGE_AW]);
  assign page[1] = 8'(bg_addr[PAGE_AW +: 5]);
  assign page[2] = 8'(obj_addr[PAGE_AW +: 4]);
  assign unused_mirror_bits = ^{bg_addr[BG_AW-1 -: BG_MIR], obj_addr[OBJ_AW-1 -: OBJ_MIR]};
  assign off   = {obj_addr[PAGE_AW-1:0], bg_addr[PAGE_AW-1:0], lcd_addr[PAGE_AW-1:0]};
  assign we    = {obj_we, bg_we, lcd_we};
  assign wdata = {obj_wdata, bg_wdata, lcd_wdata};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vmap_bank #(.BANK(b), .SZLOG(int'(BANK_SZLOG[2*b +: 2])), .PAGE_AW(PAGE_AW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we[b]), .ctl_wdata(ctl_wdata[8*b +: 8]),
      .win_page(page), .win_off(off), .win_we(we), .win_wdata(wdata),
      .win_rdata(brd[b]), .win_hit(bhit[b]));
    for (genvar w = 0; w < 3; w++) begin : g_h
      assign hits[w][b] = bhit[b][w];
    end
  end

  always_comb begin
    lcd_rdata = '0; bg_rdata = '0; obj_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      lcd_rdata = lcd_rdata | brd[b][0];
      bg_rdata  = bg_rdata  | brd[b][1];
      obj_rdata = obj_rdata | brd[b][2];
    end
  end

  p_lcd_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits[0] == '0) |-> (lcd_rdata == '0));
  p_bg_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits[1] == '0) |-> (bg_rdata == '0));
  p_obj_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits[2] == '0) |-> (obj_rdata == '0));
endmodule

// File: tb/vmap_bench.sv
module vmap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;
  // control bytes per scenario, bank 0 in the low byte
  localparam logic [31:0] SCEN [NS] = '{
    32'h0000_0000, 32'h8080_8080, 32'h9991_8981, 32'h8392_8A82,
    32'h0109_0200, 32'h899A_8180, 32'h9A00_8A82 };
  localparam int SZ [4] = '{8, 8, 4, 1};

  logic clk = 0, rst_n = 0;
  logic [3:0] ctl_we = 0;
  logic [31:0] ctl_wdata = 0;
  logic [8:0] lcd_addr = 0; logic lcd_we = 0; logic [15:0] lcd_wdata = 0, lcd_rdata;
  logic [9:0] bg_addr = 0;  logic bg_we = 0;  logic [15:0] bg_wdata = 0, bg_rdata;
  logic [8:0] obj_addr = 0; logic obj_we = 0; logic [15:0] obj_wdata = 0, obj_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] cfg [4];
  logic [15:0] mdl [4][128];

  always #(CLK_PERIOD/2) clk = ~clk;

  vmap u_vmap (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .lcd_addr(lcd_addr), .lcd_we(lcd_we), .lcd_wdata(lcd_wdata), .lcd_rdata(lcd_rdata),
    .bg_addr(bg_addr), .bg_we(bg_we), .bg_wdata(bg_wdata), .bg_rdata(bg_rdata),
    .obj_addr(obj_addr), .obj_we(obj_we), .obj_wdata(obj_wdata), .obj_rdata(obj_rdata));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // model: local page of bank b for window w, page pg; -1 when not covered
  function automatic int lp(int w, int b, int pg);
    logic [7:0] c = cfg[b];
    int p, st, slot;
    if (!c[7] || int'(c[1:0]) != w) return -1;
    if (w == 0) return (pg / 8 == b && pg % 8 < SZ[b]) ? pg % 8 : -1;
    p = (w == 1) ? pg % 32 : pg % 16;
    if (SZ[b] == 1) begin
      st = (c[3] ? 1 : 0) + (c[4] ? 4 : 0);
      return (p >= st && p < st + 8) ? 0 : -1;
    end
    slot = (w == 1) ? int'(c[4:3]) : int'(c[3]);
    return (p / 8 == slot) ? (p % 8) % SZ[b] : -1;
  endfunction

  function automatic string tag(int s);
    case (s)
      0: return "R11 all off";        1: return "R3 direct slots";
      2: return "R9 bg overlap R7";   3: return "R5 obj base R6";
      4: return "R1 disabled";        5: return "R8 mixed mirror";
      default: return "R7 obj small";
    endcase
  endfunction

  task automatic set_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 4'hF; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
    for (int b = 0; b < 4; b++) cfg[b] = v[8*b +: 8];
  endtask

  task automatic wr(input int w, input int a, input logic [15:0] d);
    @(negedge clk);
    case (w)
      0: begin lcd_addr = 9'(a); lcd_wdata = d; lcd_we = 1; end
      1: begin bg_addr = 10'(a); bg_wdata = d; bg_we = 1; end
      default: begin obj_addr = 9'(a); obj_wdata = d; obj_we = 1; end
    endcase
    @(negedge clk); lcd_we = 0; bg_we = 0; obj_we = 0;
  endtask

  task automatic rd(input int w, input int a, output logic [15:0] v);
    case (w)
      0: lcd_addr = 9'(a);
      1: bg_addr = 10'(a);
      default: obj_addr = 9'(a);
    endcase
    #1;
    v = (w == 0) ? lcd_rdata : (w == 1) ? bg_rdata : obj_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e, d;
    int li;
    repeat (3) @(posedge clk);
    // R11: reset state, nothing mapped
    rd(0, 37, v); check("R11 reset lcd", v, 16'h0);
    rd(1, 100, v); check("R11 reset bg", v, 16'h0);
    rd(2, 7, v);   check("R11 reset obj", v, 16'h0);
    rst_n = 1;
    @(negedge clk);
    rd(1, 5, v);   check("R4 unmapped after reset", v, 16'h0);

    // table walk: configure, fill each window's base span, read everything
    for (int s = 0; s < NS; s++) begin
      set_ctl(SCEN[s]);
      for (int w = 0; w < 3; w++) begin
        int span = (w == 2) ? 256 : 512;
        for (int a = 0; a < span; a++) begin
          d = 16'(s * 16'h1357) ^ 16'(w << 12) ^ 16'(a);
          wr(w, a, d);
          for (int b = 0; b < 4; b++) begin
            li = lp(w, b, a / 16);
            if (li >= 0) mdl[b][li * 16 + a % 16] = d;
          end
        end
      end
      for (int w = 0; w < 3; w++) begin
        int full = (w == 1) ? 1024 : 512;
        for (int a = 0; a < full; a++) begin
          e = '0;
          for (int b = 0; b < 4; b++) begin
            li = lp(w, b, a / 16);
            if (li >= 0) e = e | mdl[b][li * 16 + a % 16];
          end
          rd(w, a, v);
          check(tag(s), v, e);
        end
      end
    end

    // R2/R10: mode 3 hides bank, re-enable seen only after the edge, data kept
    set_ctl(32'h0000_0080);
    wr(0, 5, 16'hBEEF);
    set_ctl(32'h0000_0083);
    rd(0, 5, v); check("R2 mode3 hidden", v, 16'h0);
    @(negedge clk); ctl_we = 4'h1; ctl_wdata = 32'h0000_0080;
    rd(0, 5, v); check("R10 before edge", v, 16'h0);
    @(negedge clk); ctl_we = 0;
    rd(0, 5, v); check("R10 after edge", v, 16'hBEEF);
    set_ctl(32'h0000_0080);
    rd(0, 5, v); check("R10 same value rewrite", v, 16'hBEEF);
    // R5/R8: remap to background slot 2, data survives; mirror copy too
    set_ctl(32'h0000_0091);
    rd(1, 16*16 + 5, v); check("R5 bg slot2", v, 16'hBEEF);
    rd(1, 48*16 + 5, v); check("R8 bg mirror", v, 16'hBEEF);
    rd(0, 5, v);         check("R2 left direct window", v, 16'h0);
    // R9: write into overlap reaches both banks
    set_ctl(32'h8100_0081);
    wr(1, 2*16 + 1, 16'h1234);
    set_ctl(32'h8000_0081);
    rd(0, 24*16 + 1, v); check("R9 overlap write bank3", v, 16'h1234);
    rd(1, 2*16 + 1, v);  check("R9 overlap write bank0", v, 16'h1234);
    // R6: 4-page bank repeats inside its slot
    set_ctl(32'h0081_0000);
    wr(1, 1*16 + 3, 16'h0F0F);
    rd(1, 5*16 + 3, v); check("R6 repeat", v, 16'h0F0F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule